// File: doc/BRIEF.md
# Reset Cause Recording Register

This block keeps one sticky flag for each kind of event that can reset a chip or its CPU domain. The events are power-on, brown-out, the external reset pin, a CPU system-reset request, the independent watchdog, the window watchdog, an illegal low-power-mode entry, and the CPU-domain power switch coming back on. Boot software reads the flags to learn why the chip restarted. It then clears them all by setting a single remove control bit, and clears that bit again afterwards.

Only the power-on reset input resets the flag register. A pin, watchdog or software reset does not touch it, so the flag for that reset survives and can still be read. Every event input is a one-cycle pulse in the register clock domain. The CPU-domain flag has two sources. It is set on exit from the first deep-stop mode. On exit from the second deep-stop mode it is set only when a pin reset arrived while the domain was in that stop.

Top module: `rst_cause_rec`

## Requirements
- R1: While `por_rst` is high, and on the first cycle after it falls, the flags read back as follows. Power-on (bit 8), brown-out (bit 9), pin (bit 10) and CPU-domain (bit 11) read 1. CPU-software (bit 12), independent-watchdog (bit 13), window-watchdog (bit 14) and illegal-low-power (bit 15) read 0. The remove bit (bit 0) reads 0.
- R2: A one-cycle pulse sets its flag from the next cycle on. `ev_brownout` sets bit 9, `ev_pin` sets bit 10, `ev_cpu_sw` sets bit 12, `ev_wdg_ind` sets bit 13 and `ev_wdg_win` sets bit 14.
- R3: A pulse on either `ev_bad_lp_dom` or `ev_bad_lp_cpu` sets the illegal-low-power flag (bit 15) from the next cycle on.
- R4: A pulse on `ev_dstop1_exit` sets the CPU-domain flag (bit 11) from the next cycle on.
- R5: A pulse on `ev_dstop2_exit` sets bit 11 only in one case. There must have been an earlier `ev_dstop2_enter`, and an `ev_pin` pulse must have arrived after that entry cycle, up to and including the exit cycle. A pin pulse in the entry cycle itself does not count. An exit with no pin pulse, or with no pending entry, leaves bit 11 unchanged. The pin pulse still sets bit 10 as in R2.
- R6: A flag that is set stays set whatever the event inputs do, as long as the remove bit is 0. The power-on flag (bit 8) is set only by `por_rst`.
- R7: A write stores `reg_wdata[0]` in the remove bit, which can be read from the next cycle on. All other write-data bits are ignored.
- R8: In every cycle that the remove bit reads 1, each flag is cleared at the next edge, unless its own event pulses in that cycle. In that case the flag reads 1 for the following cycle.
- R9: Pulses on several event inputs in the same cycle set all of the matching flags together.
- R10: `reg_rdata` returns the remove bit at bit 0 and the flags at bits 8 to 15. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_rst | input | 1 | Synchronous active-high power-on reset; the only reset of this block |
| ev_brownout | input | 1 | Brown-out reset pulse |
| ev_pin | input | 1 | External pin reset pulse |
| ev_cpu_sw | input | 1 | CPU system-reset request pulse |
| ev_wdg_ind | input | 1 | Independent watchdog reset pulse |
| ev_wdg_win | input | 1 | Window watchdog reset pulse |
| ev_bad_lp_dom | input | 1 | CPU domain entered a deep-stop mode illegally |
| ev_bad_lp_cpu | input | 1 | CPU entered its stop mode illegally |
| ev_dstop1_exit | input | 1 | CPU domain left the first deep-stop mode |
| ev_dstop2_enter | input | 1 | CPU domain entered the second deep-stop mode |
| ev_dstop2_exit | input | 1 | CPU domain left the second deep-stop mode |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data; only bit 0 is used |
| reg_rdata | output | 32 | Register read data |

## Verification
The hardest case to reach is the pin reset inside the second deep-stop mode. It depends on a history of pulses spread over several cycles, not on the current inputs. The stimulus runs every variant of the stop window. The pin pulse comes mid-stop, on the exit cycle itself, on the entry cycle, or not at all, and there is also an exit with no entry before it. The remove bit is cleared before each variant, so a bit-11 flag left over from an earlier run cannot hide a wrong result. A clear that lands in the same cycle as an event is also driven on purpose, to show the one cycle in which the event wins.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int unsigned NUM_FLAGS = 8;

    // Flag vector, power-on flag at bit 0 (LSB of the packed struct).
    typedef struct packed {
        logic lowpwr;
        logic wdg_win;
        logic wdg_ind;
        logic cpu_sw;
        logic dom;
        logic pin;
        logic bor;
        logic por;
    } rcr_flags_t;

    // Raw event pulses entering the block.
    typedef struct packed {
        logic bor;
        logic pin;
        logic cpu_sw;
        logic wdg_ind;
        logic wdg_win;
        logic bad_lp_dom;
        logic bad_lp_cpu;
        logic dstop1_exit;
        logic dstop2_enter;
        logic dstop2_exit;
    } rcr_evt_t;

    localparam rcr_flags_t FLAGS_POR_PRESET = '{
        lowpwr: 1'b0, wdg_win: 1'b0, wdg_ind: 1'b0, cpu_sw: 1'b0,
        dom: 1'b1, pin: 1'b1, bor: 1'b1, por: 1'b1
    };

    function automatic rcr_flags_t map_events(rcr_evt_t e, logic dom_from_stop2);
        rcr_flags_t f;
        f.por    = 1'b0;
        f.bor    = e.bor;
        f.pin    = e.pin;
        f.dom    = e.dstop1_exit | dom_from_stop2;
        f.cpu_sw = e.cpu_sw;
        f.wdg_ind = e.wdg_ind;
        f.wdg_win = e.wdg_win;
        f.lowpwr = e.bad_lp_dom | e.bad_lp_cpu;
        return f;
    endfunction

endpackage

// File: rtl/rcr_stop2_track.sv
module rcr_stop2_track (
    input  logic clk,
    input  logic por_rst,
    input  logic enter_i,
    input  logic exit_i,
    input  logic pin_i,
    output logic dom_set_o
);
    logic in_stop_q;
    logic pin_seen_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            in_stop_q  <= 1'b0;
            pin_seen_q <= 1'b0;
        end else if (enter_i) begin
            in_stop_q  <= 1'b1;
            pin_seen_q <= 1'b0;
        end else if (exit_i) begin
            in_stop_q  <= 1'b0;
            pin_seen_q <= 1'b0;
        end else if (in_stop_q && pin_i) begin
            pin_seen_q <= 1'b1;
        end
    end

    always_comb begin
        dom_set_o = exit_i && !enter_i && in_stop_q && (pin_seen_q || pin_i);
    end

    AST_ENTER_ARMS: assert property (@(posedge clk) disable iff (por_rst)
        enter_i |=> (in_stop_q && !pin_seen_q)); // R5
    AST_EXIT_DISARMS: assert property (@(posedge clk) disable iff (por_rst)
        (exit_i && !enter_i) |=> (!in_stop_q && !pin_seen_q)); // R5
    AST_NO_PIN_NO_DOM: assert property (@(posedge clk) disable iff (por_rst)
        !in_stop_q |-> !dom_set_o); // R5

endmodule

// File: rtl/rcr_flag_bank.sv
module rcr_flag_bank #(
    parameter int unsigned        N      = 8,
    parameter logic [N-1:0]       PRESET = '0
) (
    input  logic         clk,
    input  logic         por_rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (por_rst) begin
                flag_q[i] <= PRESET[i];
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_i) begin
                flag_q[i] <= 1'b0;
            end
        end

        AST_SET_TAKES: assert property (@(posedge clk) disable iff (por_rst)
            set_i[i] |=> flag_q[i]); // R2
        AST_STICKY: assert property (@(posedge clk) disable iff (por_rst)
            (flag_q[i] && !clr_i) |=> flag_q[i]); // R6
        AST_CLEARS: assert property (@(posedge clk) disable iff (por_rst)
            (clr_i && !set_i[i]) |=> !flag_q[i]); // R8
        AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (por_rst)
            (clr_i && set_i[i]) |=> flag_q[i]); // R8
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (por_rst)
            (!flag_q[i] && !set_i[i]) |=> !flag_q[i]); // R6
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rcr_reg_port.sv
module rcr_reg_port #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned N        = 8,
    parameter int unsigned CLR_BIT  = 0,
    parameter int unsigned FLAG_LSB = 8
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              wr_i,
    input  logic              wbit_i,
    input  logic [N-1:0]      flags_i,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned FLAG_MSB = FLAG_LSB + N - 1;

    initial begin
        if (FLAG_MSB >= DATA_W || (CLR_BIT >= FLAG_LSB && CLR_BIT <= FLAG_MSB))
            $error("rcr_reg_port: field layout does not fit");
    end

    logic clr_q;

    always_ff @(posedge clk) begin
        if (por_rst)    clr_q <= 1'b0;
        else if (wr_i)  clr_q <= wbit_i;
    end

    always_comb begin
        rdata_o                  = '0;
        rdata_o[CLR_BIT]         = clr_q;
        rdata_o[FLAG_LSB +: N]   = flags_i;
    end

    assign clr_o = clr_q;

    AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (por_rst)
        wr_i |=> (clr_q == $past(wbit_i))); // R7
    AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (por_rst)
        !wr_i |=> $stable(clr_q)); // R7

endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import rcr_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CLR_BIT  = 0,
    parameter int unsigned FLAG_LSB = 8
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              ev_brownout,
    input  logic              ev_pin,
    input  logic              ev_cpu_sw,
    input  logic              ev_wdg_ind,
    input  logic              ev_wdg_win,
    input  logic              ev_bad_lp_dom,
    input  logic              ev_bad_lp_cpu,
    input  logic              ev_dstop1_exit,
    input  logic              ev_dstop2_enter,
    input  logic              ev_dstop2_exit,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int unsigned N = NUM_FLAGS;

    rcr_evt_t   evt;
    rcr_flags_t set_vec;
    rcr_flags_t flags;
    logic       dom_from_stop2;
    logic       clr;
    logic       wdata_unused;

    assign wdata_unused = ^reg_wdata;

    always_comb begin
        evt.bor          = ev_brownout;
        evt.pin          = ev_pin;
        evt.cpu_sw       = ev_cpu_sw;
        evt.wdg_ind      = ev_wdg_ind;
        evt.wdg_win      = ev_wdg_win;
        evt.bad_lp_dom   = ev_bad_lp_dom;
        evt.bad_lp_cpu   = ev_bad_lp_cpu;
        evt.dstop1_exit  = ev_dstop1_exit;
        evt.dstop2_enter = ev_dstop2_enter;
        evt.dstop2_exit  = ev_dstop2_exit;
    end

    rcr_stop2_track u_stop2 (
        .clk       (clk),
        .por_rst   (por_rst),
        .enter_i   (evt.dstop2_enter),
        .exit_i    (evt.dstop2_exit),
        .pin_i     (evt.pin),
        .dom_set_o (dom_from_stop2)
    );

    assign set_vec = map_events(evt, dom_from_stop2);

    rcr_flag_bank #(
        .N      (N),
        .PRESET (FLAGS_POR_PRESET)
    ) u_bank (
        .clk     (clk),
        .por_rst (por_rst),
        .set_i   (set_vec),
        .clr_i   (clr),
        .flag_o  (flags)
    );

    rcr_reg_port #(
        .DATA_W   (DATA_W),
        .N        (N),
        .CLR_BIT  (CLR_BIT),
        .FLAG_LSB (FLAG_LSB)
    ) u_port (
        .clk     (clk),
        .por_rst (por_rst),
        .wr_i    (reg_wr),
        .wbit_i  (reg_wdata[CLR_BIT]),
        .flags_i (flags),
        .clr_o   (clr),
        .rdata_o (reg_rdata)
    );

    AST_POR_PRESET: assert property (@(posedge clk) disable iff (por_rst)
        $fell(por_rst) |-> (reg_rdata[FLAG_LSB +: N] == FLAGS_POR_PRESET
                            && !reg_rdata[CLR_BIT])); // R1
    AST_POR_FLAG_ONLY_RESET: assert property (@(posedge clk) disable iff (por_rst)
        !flags.por |=> !flags.por); // R6
    AST_LP_EITHER: assert property (@(posedge clk) disable iff (por_rst)
        (ev_bad_lp_dom || ev_bad_lp_cpu) |=> flags.lowpwr); // R3
    AST_DSTOP1_DOM: assert property (@(posedge clk) disable iff (por_rst)
        ev_dstop1_exit |=> flags.dom); // R4
    AST_MULTI_SET: assert property (@(posedge clk) disable iff (por_rst)
        (ev_brownout && ev_wdg_ind) |=> (flags.bor && flags.wdg_ind)); // R9

endmodule

// File: tb/tb_rst_cause_rec.sv
module tb_rst_cause_rec;

    logic        clk = 1'b0;
    logic        por_rst;
    logic        ev_brownout, ev_pin, ev_cpu_sw, ev_wdg_ind, ev_wdg_win;
    logic        ev_bad_lp_dom, ev_bad_lp_cpu, ev_dstop1_exit;
    logic        ev_dstop2_enter, ev_dstop2_exit;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    always #5 clk = ~clk;

    rst_cause_rec dut (
        .clk(clk), .por_rst(por_rst),
        .ev_brownout(ev_brownout), .ev_pin(ev_pin), .ev_cpu_sw(ev_cpu_sw),
        .ev_wdg_ind(ev_wdg_ind), .ev_wdg_win(ev_wdg_win),
        .ev_bad_lp_dom(ev_bad_lp_dom), .ev_bad_lp_cpu(ev_bad_lp_cpu),
        .ev_dstop1_exit(ev_dstop1_exit), .ev_dstop2_enter(ev_dstop2_enter),
        .ev_dstop2_exit(ev_dstop2_exit), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Reference model state: flag bits por0 bor1 pin2 dom3 sw4 iwdg5 wwdg6 lp7
    bit [7:0] m_flags;
    bit       m_clr;
    bit       m_in2;
    bit       m_pin2;
    int       n_cmp = 0;
    int       n_bad = 0;
    string    cur_req = "R1";

    task automatic idle_inputs();
        ev_brownout = 0; ev_pin = 0; ev_cpu_sw = 0; ev_wdg_ind = 0;
        ev_wdg_win = 0; ev_bad_lp_dom = 0; ev_bad_lp_cpu = 0;
        ev_dstop1_exit = 0; ev_dstop2_enter = 0; ev_dstop2_exit = 0;
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic model_edge();
        bit [7:0] s;
        if (por_rst) begin
            m_flags = 8'h0F; m_clr = 0; m_in2 = 0; m_pin2 = 0;
            return;
        end
        s = '0;
        s[1] = ev_brownout;
        s[2] = ev_pin;
        s[3] = ev_dstop1_exit ||
               (ev_dstop2_exit && !ev_dstop2_enter && m_in2 && (m_pin2 || ev_pin));
        s[4] = ev_cpu_sw;
        s[5] = ev_wdg_ind;
        s[6] = ev_wdg_win;
        s[7] = ev_bad_lp_dom || ev_bad_lp_cpu;
        m_flags = s | (m_clr ? 8'h00 : m_flags);
        if (reg_wr) m_clr = reg_wdata[0];
        if (ev_dstop2_enter) begin m_in2 = 1; m_pin2 = 0; end
        else if (ev_dstop2_exit) begin m_in2 = 0; m_pin2 = 0; end
        else if (m_in2 && ev_pin) m_pin2 = 1;
    endtask

    task automatic compare();
        logic [31:0] exp;
        exp = {16'h0, m_flags, 7'h0, m_clr};
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata actual %08h expected %08h at %0t",
                     cur_req, reg_rdata, exp, $time);
        end
    endtask

    // One clock: inputs already driven; update model at edge, check at negedge.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic write_clr(bit v, logic [31:0] other);
        reg_wr = 1; reg_wdata = (other & 32'hFFFF_FFFE) | {31'h0, v};
        cyc();
    endtask

    task automatic clear_all();
        write_clr(1'b1, 32'h0);
        idle(1);
        write_clr(1'b0, 32'h0);
    endtask

    initial begin
        idle_inputs();
        por_rst = 1;
        @(negedge clk);
        cur_req = "R1"; idle(3);
        por_rst = 0;
        cur_req = "R1_R10"; idle(2);

        cur_req = "R7"; write_clr(1'b0, 32'hFFFF_FF00); idle(2);
        write_clr(1'b1, 32'h1234_5600); idle(2);
        cur_req = "R8"; ev_wdg_win = 1; cyc(); idle(2);
        ev_pin = 1; ev_cpu_sw = 1; cyc(); idle(1);
        cur_req = "R7"; write_clr(1'b0, 32'hAAAA_AAAA); idle(1);

        cur_req = "R2"; ev_brownout = 1; cyc(); idle(1);
        ev_pin = 1; cyc(); idle(1);
        ev_cpu_sw = 1; cyc(); idle(1);
        ev_wdg_ind = 1; cyc(); idle(1);
        ev_wdg_win = 1; cyc(); idle(1);
        cur_req = "R6"; ev_pin = 1; ev_wdg_ind = 1; cyc(); ev_dstop2_enter = 1; cyc();
        ev_dstop2_exit = 1; cyc(); idle(3);
        clear_all();

        cur_req = "R3"; ev_bad_lp_dom = 1; cyc(); idle(1);
        clear_all();
        ev_bad_lp_cpu = 1; cyc(); idle(1);
        clear_all();

        cur_req = "R4"; ev_dstop1_exit = 1; cyc(); idle(1);
        clear_all();

        cur_req = "R5"; ev_dstop2_enter = 1; cyc(); idle(2); ev_dstop2_exit = 1; cyc(); idle(1);
        clear_all();
        ev_dstop2_enter = 1; cyc(); idle(1); ev_pin = 1; cyc(); idle(2);
        ev_dstop2_exit = 1; cyc(); idle(1);
        clear_all();
        ev_dstop2_enter = 1; cyc(); idle(1); ev_pin = 1; ev_dstop2_exit = 1; cyc(); idle(1);
        clear_all();
        ev_dstop2_enter = 1; ev_pin = 1; cyc(); idle(1); ev_dstop2_exit = 1; cyc(); idle(1);
        clear_all();
        ev_pin = 1; ev_dstop2_exit = 1; cyc(); idle(1);
        clear_all();
        ev_dstop2_enter = 1; cyc(); ev_pin = 1; cyc(); ev_dstop2_exit = 1; cyc();
        clear_all();
        ev_dstop2_exit = 1; cyc(); idle(1);

        cur_req = "R9"; ev_brownout = 1; ev_pin = 1; ev_cpu_sw = 1; ev_wdg_ind = 1;
        ev_wdg_win = 1; ev_bad_lp_cpu = 1; ev_dstop1_exit = 1; cyc(); idle(2);
        clear_all();
        ev_brownout = 1; ev_wdg_ind = 1; cyc(); idle(1);

        cur_req = "R1"; clear_all(); write_clr(1'b1, 32'h0);
        por_rst = 1; idle(2); por_rst = 0; idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule